// File: doc/BRIEF.md
# Adjacent Memory Pair Fuser

This block sits in the decode stage of a wide front end and looks at one group of decoded word-sized memory instructions per cycle. The slots are in program order. When two neighbouring slots hold the same kind of access (two loads or two stores), address the same base register, and the second offset is exactly one word above the first, the pair can be served by a single doubleword access. An external combining predictor supplies one gate bit per neighbouring slot pair. The block rewrites only the pairs that the predictor expects to be aligned.

A fused load pair becomes a doubleword load into the first destination, followed by an extract of the upper word into the second destination. A fused store pair becomes a merge of the two source registers into the merge buffer, followed by a doubleword store. Each rewrite still fills two slots, so the group width never changes. When the memory side reports a misalignment, the front end refetches the group and drives the replay input. The block then passes every instruction through unchanged. Results appear one clock after the group is presented.

Top module: `mem_pair_fuser`

## Requirements
- R1: While reset is asserted, and on the first edge after it, all out_valid bits are 0.
- R2: Each output slot shows the instruction presented one clock earlier in the same slot, with out_valid equal to its in_valid. An instruction that is not fused keeps its fields: op 0 (plain load) or 1 (plain store), ra = in_reg, rb = in_base, imm = in_off.
- R3: A fused load pair in slots i and i+1 gives slot i op 2 (doubleword load) with ra = first destination, rb = base, imm = first offset. Slot i+1 gets op 3 (extract high) with ra = second destination, rb = first destination, imm = 0.
- R4: A fused store pair gives slot i op 4 (merge) with ra = first source, rb = second source, imm = 0. Slot i+1 gets op 5 (doubleword store) with ra = 0, rb = base, imm = first offset.
- R5: Only valid instructions in directly adjacent slots that are both loads or both stores are fused. A mixed pair, or a pair separated by an invalid slot, passes through.
- R6: Fusion needs equal base registers and a second offset equal to the first offset plus 4, computed as a signed value without wraparound. A descending step, a step of 8, and a step that overflows the offset width all pass through. Negative offsets fuse normally.
- R7: pair_pred[i] gates the pair (i, i+1). When it is 0, that pair is not fused.
- R8: While replay_mode is 1, no slot of the resulting group carries ops 2 to 5. Fusion resumes on the first group presented with replay_mode at 0.
- R9: Each instruction belongs to at most one fused pair. Pairs are chosen greedily from slot 0 upward, so four loads at offsets 0, 4, 8, 12 become two pairs, and three loads at 0, 4, 8 leave the third unfused.
- R10: A load pair whose first or second destination equals the base register is not fused. Stores whose source equals the base register still fuse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | SLOTS | Slot holds an instruction |
| in_is_store | input | SLOTS | 1 = store, 0 = load |
| in_base | input | SLOTS*REG_W | Base register per slot |
| in_off | input | SLOTS*OFF_W | Signed byte offset per slot |
| in_reg | input | SLOTS*REG_W | Load destination or store source |
| pair_pred | input | SLOTS-1 | Aligned prediction for pair (i, i+1) |
| replay_mode | input | 1 | Disable every rewrite |
| out_valid | output | SLOTS | Output slot valid |
| out_op | output | SLOTS*3 | Op code per slot (0..5) |
| out_ra | output | SLOTS*REG_W | First register field |
| out_rb | output | SLOTS*REG_W | Second register field |
| out_imm | output | SLOTS*OFF_W | Immediate field |

## Verification
Directed groups pit qualifying pairs against near misses that differ in only one condition: class, adjacency, base, step direction, step size, signed overflow or a destination that clobbers the base. Each near miss shows which single condition the match logic actually tests. Runs of three and four loads under different predictor masks separate greedy oldest-first selection from any other pairing order. Replay is applied and then released on the same group, which shows that it suppresses rewrites and does not latch.

// File: rtl/mpf_pkg.sv
package mpf_pkg;
   localparam int OP_W       = 3;
   localparam int WORD_BYTES = 4;

   typedef enum logic [OP_W-1:0] {
      OP_LW    = 3'd0,
      OP_SW    = 3'd1,
      OP_DLW   = 3'd2,
      OP_EXTHI = 3'd3,
      OP_MERGE = 3'd4,
      OP_DSW   = 3'd5
   } op_e;
endpackage

// File: rtl/mpf_pair_match.sv
// Decides whether two neighbouring slots form a fusable pair.
module mpf_pair_match #(
   parameter int REG_W = 5,
   parameter int OFF_W = 16,
   parameter int STEP  = 4
) (
   input  logic             v_a,
   input  logic             v_b,
   input  logic             st_a,
   input  logic             st_b,
   input  logic [REG_W-1:0] base_a,
   input  logic [REG_W-1:0] base_b,
   input  logic [OFF_W-1:0] off_a,
   input  logic [OFF_W-1:0] off_b,
   input  logic [REG_W-1:0] reg_a,
   input  logic [REG_W-1:0] reg_b,
   output logic             match
);
   localparam int EXT_W = OFF_W + 1;

   logic [EXT_W-1:0] ext_a, ext_b, next_a;
   logic             step_ok, same_kind, same_base, base_safe;

   // one extra sign bit keeps the +STEP comparison free of wraparound
   assign ext_a   = {off_a[OFF_W-1], off_a};
   assign ext_b   = {off_b[OFF_W-1], off_b};
   assign next_a  = ext_a + EXT_W'(STEP);
   assign step_ok = (next_a == ext_b);

   assign same_kind = (st_a == st_b);
   assign same_base = (base_a == base_b);
   // loads writing the base change the address seen by the second access
   assign base_safe = st_a | ((reg_a != base_a) && (reg_b != base_a));

   assign match = v_a & v_b & same_kind & same_base & step_ok & base_safe;
endmodule

// File: rtl/mpf_pair_select.sv
// Greedy oldest-first choice of pair heads; a slot joins at most one pair.
module mpf_pair_select #(
   parameter int SLOTS = 4
) (
   input  logic [SLOTS-2:0] cand,
   input  logic [SLOTS-2:0] allow,
   output logic [SLOTS-1:0] head,
   output logic [SLOTS-1:0] tail
);
   logic [SLOTS-2:0] take;
   assign take = cand & allow;

   for (genvar i = 0; i < SLOTS; i++) begin : g_chain
      if (i == 0) begin : g_first
         assign head[i] = take[i];
         assign tail[i] = 1'b0;
      end else if (i < SLOTS - 1) begin : g_mid
         assign head[i] = take[i] & ~head[i-1];
         assign tail[i] = head[i-1];
      end else begin : g_last
         assign head[i] = 1'b0;
         assign tail[i] = head[i-1];
      end
   end
endmodule

// File: rtl/mpf_slot_emit.sv
// Forms the output op of one slot from its role in a pair.
module mpf_slot_emit import mpf_pkg::*; #(
   parameter int REG_W = 5,
   parameter int OFF_W = 16
) (
   input  logic             is_store,
   input  logic             head,
   input  logic             tail,
   input  logic [REG_W-1:0] reg_self,
   input  logic [REG_W-1:0] base_self,
   input  logic [OFF_W-1:0] off_self,
   input  logic [REG_W-1:0] reg_prev,
   input  logic [REG_W-1:0] base_prev,
   input  logic [OFF_W-1:0] off_prev,
   input  logic [REG_W-1:0] reg_next,
   output op_e              op,
   output logic [REG_W-1:0] ra,
   output logic [REG_W-1:0] rb,
   output logic [OFF_W-1:0] imm
);
   always_comb begin
      op  = is_store ? OP_SW : OP_LW;
      ra  = reg_self;
      rb  = base_self;
      imm = off_self;
      if (head) begin
         if (is_store) begin
            op  = OP_MERGE;
            rb  = reg_next;
            imm = '0;
         end else begin
            op  = OP_DLW;
         end
      end else if (tail) begin
         if (is_store) begin
            op  = OP_DSW;
            ra  = '0;
            rb  = base_prev;
            imm = off_prev;
         end else begin
            op  = OP_EXTHI;
            rb  = reg_prev;
            imm = '0;
         end
      end
   end
endmodule

// File: rtl/mem_pair_fuser.sv
module mem_pair_fuser import mpf_pkg::*; #(
   parameter int SLOTS   = 4,
   parameter int REG_W   = 5,
   parameter int OFF_W   = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [SLOTS-1:0]       in_valid,
   input  logic [SLOTS-1:0]       in_is_store,
   input  logic [SLOTS*REG_W-1:0] in_base,
   input  logic [SLOTS*OFF_W-1:0] in_off,
   input  logic [SLOTS*REG_W-1:0] in_reg,
   input  logic [SLOTS-2:0]       pair_pred,
   input  logic                   replay_mode,
   output logic [SLOTS-1:0]       out_valid,
   output logic [SLOTS*OP_W-1:0]  out_op,
   output logic [SLOTS*REG_W-1:0] out_ra,
   output logic [SLOTS*REG_W-1:0] out_rb,
   output logic [SLOTS*OFF_W-1:0] out_imm
);
   localparam int PAIRS = SLOTS - 1;

   if (SLOTS < 2) begin : g_bad_slots
      $error("mem_pair_fuser: SLOTS must be at least 2");
   end
   if (REG_W < 1) begin : g_bad_reg
      $error("mem_pair_fuser: REG_W must be positive");
   end
   if (OFF_W < 4) begin : g_bad_off
      $error("mem_pair_fuser: OFF_W must hold a one-word step");
   end

   logic [REG_W-1:0] base_s [SLOTS];
   logic [REG_W-1:0] reg_s  [SLOTS];
   logic [OFF_W-1:0] off_s  [SLOTS];

   logic [PAIRS-1:0] cand, allow;
   logic [SLOTS-1:0] head, tail;

   logic [SLOTS*OP_W-1:0]  nx_op;
   logic [SLOTS*REG_W-1:0] nx_ra, nx_rb;
   logic [SLOTS*OFF_W-1:0] nx_imm;

   for (genvar i = 0; i < SLOTS; i++) begin : g_unpack
      assign base_s[i] = in_base[i*REG_W +: REG_W];
      assign reg_s[i]  = in_reg[i*REG_W +: REG_W];
      assign off_s[i]  = in_off[i*OFF_W +: OFF_W];
   end

   // replay forces the untransformed stream for every pair
   assign allow = pair_pred & {PAIRS{~replay_mode}};

   for (genvar i = 0; i < PAIRS; i++) begin : g_match
      mpf_pair_match #(.REG_W(REG_W), .OFF_W(OFF_W), .STEP(WORD_BYTES)) u_match (
         .v_a    (in_valid[i]),
         .v_b    (in_valid[i+1]),
         .st_a   (in_is_store[i]),
         .st_b   (in_is_store[i+1]),
         .base_a (base_s[i]),
         .base_b (base_s[i+1]),
         .off_a  (off_s[i]),
         .off_b  (off_s[i+1]),
         .reg_a  (reg_s[i]),
         .reg_b  (reg_s[i+1]),
         .match  (cand[i])
      );
   end

   mpf_pair_select #(.SLOTS(SLOTS)) u_select (
      .cand  (cand),
      .allow (allow),
      .head  (head),
      .tail  (tail)
   );

   for (genvar i = 0; i < SLOTS; i++) begin : g_emit
      localparam int PI = (i == 0) ? 0 : i - 1;
      localparam int NI = (i == SLOTS - 1) ? i : i + 1;
      op_e op_i;

      mpf_slot_emit #(.REG_W(REG_W), .OFF_W(OFF_W)) u_emit (
         .is_store  (in_is_store[i]),
         .head      (head[i]),
         .tail      (tail[i]),
         .reg_self  (reg_s[i]),
         .base_self (base_s[i]),
         .off_self  (off_s[i]),
         .reg_prev  (reg_s[PI]),
         .base_prev (base_s[PI]),
         .off_prev  (off_s[PI]),
         .reg_next  (reg_s[NI]),
         .op        (op_i),
         .ra        (nx_ra[i*REG_W +: REG_W]),
         .rb        (nx_rb[i*REG_W +: REG_W]),
         .imm       (nx_imm[i*OFF_W +: OFF_W])
      );
      assign nx_op[i*OP_W +: OP_W] = op_i;
   end

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= '0;
            out_op    <= '0;
            out_ra    <= '0;
            out_rb    <= '0;
            out_imm   <= '0;
         end else begin
            out_valid <= in_valid;
            out_op    <= nx_op;
            out_ra    <= nx_ra;
            out_rb    <= nx_rb;
            out_imm   <= nx_imm;
         end
      end

      logic any_xform;
      always_comb begin
         any_xform = 1'b0;
         for (int s = 0; s < SLOTS; s++) begin
            if (out_valid[s] && (out_op[s*OP_W +: OP_W] >= OP_DLW)) any_xform = 1'b1;
         end
      end

      assert_replay_plain_R8: assert property (@(posedge clk) disable iff (!rst_n)
         replay_mode |=> !any_xform)
         else $error("rewrite emitted for a replayed group");
   end else begin : g_comb_out
      assign out_valid = in_valid;
      assign out_op    = nx_op;
      assign out_ra    = nx_ra;
      assign out_rb    = nx_rb;
      assign out_imm   = nx_imm;
   end

   // pair structure seen at the outputs
   for (genvar i = 0; i < PAIRS; i++) begin : g_chk
      assert_load_head_extract_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid[i] && out_op[i*OP_W +: OP_W] == OP_DLW) |->
         (out_valid[i+1] && out_op[(i+1)*OP_W +: OP_W] == OP_EXTHI &&
          out_rb[(i+1)*REG_W +: REG_W] == out_ra[i*REG_W +: REG_W]))
         else $error("doubleword load without matching extract");

      assert_store_head_dsw_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid[i] && out_op[i*OP_W +: OP_W] == OP_MERGE) |->
         (out_valid[i+1] && out_op[(i+1)*OP_W +: OP_W] == OP_DSW))
         else $error("merge without matching doubleword store");

      assert_tail_has_head_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid[i+1] && (out_op[(i+1)*OP_W +: OP_W] == OP_EXTHI ||
                             out_op[(i+1)*OP_W +: OP_W] == OP_DSW)) |->
         (out_op[i*OP_W +: OP_W] == OP_DLW || out_op[i*OP_W +: OP_W] == OP_MERGE))
         else $error("pair tail without a head in the previous slot");
   end

   assert_tail_not_slot0_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[0] |-> (out_op[OP_W-1:0] != OP_EXTHI && out_op[OP_W-1:0] != OP_DSW))
      else $error("slot 0 carries a pair tail");
endmodule

// File: tb/mem_pair_fuser_bench.sv
module mem_pair_fuser_bench;
   localparam int SLOTS = 4;
   localparam int REG_W = 5;
   localparam int OFF_W = 16;
   localparam int OP_W  = 3;

   localparam logic [2:0] LW = 3'd0, SW = 3'd1, DLW = 3'd2, EXT = 3'd3, MRG = 3'd4, DSW = 3'd5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [SLOTS-1:0]       in_valid, in_is_store;
   logic [SLOTS*REG_W-1:0] in_base, in_reg;
   logic [SLOTS*OFF_W-1:0] in_off;
   logic [SLOTS-2:0]       pair_pred;
   logic                   replay_mode;
   logic [SLOTS-1:0]       out_valid;
   logic [SLOTS*OP_W-1:0]  out_op;
   logic [SLOTS*REG_W-1:0] out_ra, out_rb;
   logic [SLOTS*OFF_W-1:0] out_imm;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   mem_pair_fuser u_mem_pair_fuser (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_store(in_is_store),
      .in_base(in_base), .in_off(in_off), .in_reg(in_reg), .pair_pred(pair_pred),
      .replay_mode(replay_mode), .out_valid(out_valid), .out_op(out_op),
      .out_ra(out_ra), .out_rb(out_rb), .out_imm(out_imm)
   );

   task automatic clear_in();
      in_valid = '0; in_is_store = '0; in_base = '0; in_reg = '0; in_off = '0;
      pair_pred = '1; replay_mode = 1'b0;
   endtask

   task automatic put(input int s, input logic st, input int base, input int off, input int rg);
      in_valid[s] = 1'b1;
      in_is_store[s] = st;
      in_base[s*REG_W +: REG_W] = REG_W'(base);
      in_off[s*OFF_W +: OFF_W] = OFF_W'(off);
      in_reg[s*REG_W +: REG_W] = REG_W'(rg);
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_slot(input int s, input logic v, input logic [2:0] op,
                              input int ra, input int rb, input int imm, input string req);
      logic [2:0] a_op;
      logic [REG_W-1:0] a_ra, a_rb;
      logic [OFF_W-1:0] a_imm;
      a_op = out_op[s*OP_W +: OP_W];
      a_ra = out_ra[s*REG_W +: REG_W];
      a_rb = out_rb[s*REG_W +: REG_W];
      a_imm = out_imm[s*OFF_W +: OFF_W];
      checks++;
      if (out_valid[s] !== v) begin
         errors++;
         $display("FAIL %s slot %0d valid actual %b expected %b", req, s, out_valid[s], v);
      end else if (v && (a_op !== op || a_ra !== REG_W'(ra) || a_rb !== REG_W'(rb) || a_imm !== OFF_W'(imm))) begin
         errors++;
         $display("FAIL %s slot %0d actual op%0d ra%0d rb%0d imm%h expected op%0d ra%0d rb%0d imm%h",
                  req, s, a_op, a_ra, a_rb, a_imm, op, REG_W'(ra), REG_W'(rb), OFF_W'(imm));
      end
   endtask

   task automatic t_reset();
      checks++;
      if (out_valid !== '0) begin
         errors++;
         $display("FAIL R1 out_valid actual %b expected 0000", out_valid);
      end
   endtask

   task automatic t_load_pair();
      clear_in(); put(0, 0, 10, 0, 1); put(1, 0, 10, 4, 2); step();
      expect_slot(0, 1, DLW, 1, 10, 0, "R3");
      expect_slot(1, 1, EXT, 2, 1, 0, "R3");
      expect_slot(2, 0, LW, 0, 0, 0, "R2");
   endtask

   task automatic t_store_pair();
      clear_in(); put(2, 1, 11, 8, 3); put(3, 1, 11, 12, 4); step();
      expect_slot(2, 1, MRG, 3, 4, 0, "R4");
      expect_slot(3, 1, DSW, 0, 11, 8, "R4");
      expect_slot(0, 0, LW, 0, 0, 0, "R2");
   endtask

   task automatic t_kind_and_gap();
      clear_in(); put(0, 0, 10, 0, 1); put(1, 1, 10, 4, 2); step();
      expect_slot(0, 1, LW, 1, 10, 0, "R5 mixed");
      expect_slot(1, 1, SW, 2, 10, 4, "R5 mixed");
      clear_in(); put(0, 0, 10, 0, 1); put(2, 0, 10, 4, 2); step();
      expect_slot(0, 1, LW, 1, 10, 0, "R5 gap");
      expect_slot(1, 0, LW, 0, 0, 0, "R5 gap");
      expect_slot(2, 1, LW, 2, 10, 4, "R5 gap");
   endtask

   task automatic t_base_offset();
      clear_in(); put(0, 0, 10, 0, 1); put(1, 0, 12, 4, 2); step();
      expect_slot(0, 1, LW, 1, 10, 0, "R6 base");
      clear_in(); put(0, 0, 10, 4, 1); put(1, 0, 10, 0, 2); step();
      expect_slot(0, 1, LW, 1, 10, 4, "R6 descending");
      clear_in(); put(0, 1, 10, 0, 1); put(1, 1, 10, 8, 2); step();
      expect_slot(0, 1, SW, 1, 10, 0, "R6 step8");
      clear_in(); put(0, 0, 10, 'h7FFE, 1); put(1, 0, 10, 'h8002, 2); step();
      expect_slot(0, 1, LW, 1, 10, 'h7FFE, "R6 overflow");
      expect_slot(1, 1, LW, 2, 10, 'h8002, "R6 overflow");
      clear_in(); put(1, 0, 9, -8, 3); put(2, 0, 9, -4, 4); step();
      expect_slot(1, 1, DLW, 3, 9, 'hFFF8, "R6 negative");
      expect_slot(2, 1, EXT, 4, 3, 0, "R6 negative");
   endtask

   task automatic t_predict();
      clear_in(); put(0, 0, 10, 0, 1); put(1, 0, 10, 4, 2); pair_pred = 3'b000; step();
      expect_slot(0, 1, LW, 1, 10, 0, "R7");
      expect_slot(1, 1, LW, 2, 10, 4, "R7");
      clear_in();
      for (int s = 0; s < 4; s++) put(s, 0, 10, 4*s, s+1);
      pair_pred = 3'b010; step();
      expect_slot(0, 1, LW, 1, 10, 0, "R7 mask");
      expect_slot(1, 1, DLW, 2, 10, 4, "R7 mask");
      expect_slot(2, 1, EXT, 3, 2, 0, "R7 mask");
      expect_slot(3, 1, LW, 4, 10, 12, "R7 mask");
   endtask

   task automatic t_replay();
      clear_in(); put(0, 1, 10, 0, 1); put(1, 1, 10, 4, 2); replay_mode = 1'b1; step();
      expect_slot(0, 1, SW, 1, 10, 0, "R8 replay");
      expect_slot(1, 1, SW, 2, 10, 4, "R8 replay");
      replay_mode = 1'b0; step();
      expect_slot(0, 1, MRG, 1, 2, 0, "R8 resume");
      expect_slot(1, 1, DSW, 0, 10, 0, "R8 resume");
   endtask

   task automatic t_greedy();
      clear_in();
      for (int s = 0; s < 4; s++) put(s, 0, 10, 4*s, s+1);
      step();
      expect_slot(0, 1, DLW, 1, 10, 0, "R9 four");
      expect_slot(1, 1, EXT, 2, 1, 0, "R9 four");
      expect_slot(2, 1, DLW, 3, 10, 8, "R9 four");
      expect_slot(3, 1, EXT, 4, 3, 0, "R9 four");
      clear_in();
      for (int s = 0; s < 3; s++) put(s, 0, 10, 4*s, s+1);
      step();
      expect_slot(0, 1, DLW, 1, 10, 0, "R9 three");
      expect_slot(1, 1, EXT, 2, 1, 0, "R9 three");
      expect_slot(2, 1, LW, 3, 10, 8, "R9 three");
      expect_slot(3, 0, LW, 0, 0, 0, "R9 three");
   endtask

   task automatic t_base_clobber();
      clear_in(); put(0, 0, 10, 0, 1); put(1, 0, 10, 4, 10); step();
      expect_slot(0, 1, LW, 1, 10, 0, "R10 second");
      expect_slot(1, 1, LW, 10, 10, 4, "R10 second");
      clear_in(); put(0, 0, 10, 0, 10); put(1, 0, 10, 4, 2); step();
      expect_slot(0, 1, LW, 10, 10, 0, "R10 first");
      clear_in(); put(0, 1, 10, 0, 10); put(1, 1, 10, 4, 11); step();
      expect_slot(0, 1, MRG, 10, 11, 0, "R10 store");
      expect_slot(1, 1, DSW, 0, 10, 0, "R10 store");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      clear_in();
      put(0, 0, 10, 0, 1); put(1, 0, 10, 4, 2);
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_load_pair();
      t_store_pair();
      t_kind_and_gap();
      t_base_offset();
      t_predict();
      t_replay();
      t_greedy();
      t_base_clobber();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule